// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block stands in for a small embedded flash array together with its status readout. A host writes unlock-and-command byte sequences over an 8-bit bus gated by a select input. A byte-program or sector-erase command then starts an internal operation whose length is set in clock cycles by parameters. While that operation runs, reads return a status byte in place of array contents. Bit 6 flips on every read. Bit 5 latches a failed program. Bit 3 reports whether the window for adding more sectors to an erase has closed.

The storage is a register array of `2**SEC_W` sectors of `2**OFS_W` bytes each. Each sector has a protect input. Programming can only clear bits: the stored byte becomes the old byte ANDed with the new data. Erasing sets every byte of a sector to 0xFF. Host software tells that an operation has finished when two reads in a row return the same value.

Top module: `flash_status_resp`

## Requirements
- R1: After reset the array reads 0xFF everywhere, `rdata` is 0x00, no operation is running and the toggle bit starts at 0.
- R2: A program command is four writes: 0xAA at offset 0x5, 0x55 at offset 0xA, 0xA0 at offset 0x5, then the data at the target address. The offset is the low OFS_W address bits. After it, each read returns a status byte, and bit 6 holds the toggle value, which inverts after every such read and nowhere else.
- R3: Once PROG_CYC cycles have passed, reads return array data again, and the target byte holds the old value ANDed with the written data.
- R4: A program command whose target sector has its protect input high starts no operation, and the byte is left unchanged.
- R5: If a program tries to turn any 0 bit into 1, status bit 5 becomes 1 when the program ends and status reads continue with bit 6 toggling. A write of 0xF0 to any address clears bit 5 and returns the block to array reads.
- R6: A sector-erase command is six writes: 0xAA@0x5, 0x55@0xA, 0x80@0x5, 0xAA@0x5, 0x55@0xA, then 0x30 at any address in the sector. Status bit 3 reads 0 for ERASE_WINDOW_CYC cycles, then reads 1 for ERASE_CYC cycles, after which the sector reads 0xFF.
- R7: A write of 0x30 during the window adds the sector of its address to the erase, closes the window at once (bit 3 reads 1), and both sectors are erased.
- R8: If every selected sector is protected, status reads with bit 3 at 1 last PROT_ERASE_CYC cycles after the window, and then reads return array data with nothing erased.
- R9: Command writes other than 0xF0 that arrive while an operation runs are ignored.
- R10: In every status read, bits 7, 4, 2, 1 and 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Flash select; a read or write counts only when it is high |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| addr | input | SEC_W+OFS_W | Byte address; the upper SEC_W bits pick the sector |
| wdata | input | 8 | Write data or command byte |
| prot | input | 2**SEC_W | Per-sector protect flags |
| rdata | output | 8 | Read data, registered; array byte or status byte |

## Verification
The bench tracks the toggle bit across every status read from reset onward, including reads made in the error-hold state. A design that flips the bit on a clock tick, or resets it at the start of each operation, breaks that sequence. It programs a 0 bit back to 1 to check both that the error latches and that the stored byte does not rise, which catches a design that overwrites the byte instead of ANDing. It erases with an appended sector, erases a protected sector, and sends a program command while an operation is running. A design that lets the window run to its end after an append, erases a protected sector, or accepts commands while busy leaves the wrong bytes in the array or the wrong value in bit 3.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WIN,
    ST_ERASE,
    ST_PWAIT,
    ST_FAULT
  } fsr_state_e;

  localparam logic [7:0] CMD_UNLK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLK2 = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam int unsigned OFS_UNLK1 = 5;
  localparam int unsigned OFS_UNLK2 = 10;
endpackage

// File: rtl/fsr_cmd_decode.sv
module fsr_cmd_decode
  import fsr_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             cmd_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [7:0]       wdata,
  output logic             prog_go,
  output logic             erase_go,
  output logic             sect_hit,
  output logic             reset_hit
);
  logic [2:0] step_q, step_d;
  logic       ers_mode_q, ers_mode_d;
  logic       wr_ok, at1, at2;

  assign wr_ok     = wr && cmd_en;
  assign at1       = (ofs == OFS_W'(OFS_UNLK1));
  assign at2       = (ofs == OFS_W'(OFS_UNLK2));
  assign reset_hit = wr && (wdata == CMD_RESET);
  assign sect_hit  = wr && (wdata == CMD_SECT);

  always_comb begin
    step_d     = step_q;
    ers_mode_d = ers_mode_q;
    prog_go    = 1'b0;
    erase_go   = 1'b0;
    if (reset_hit) begin
      step_d = 3'd0;
    end else if (wr_ok) begin
      case (step_q)
        3'd0: step_d = (wdata == CMD_UNLK1 && at1) ? 3'd1 : 3'd0;
        3'd1: step_d = (wdata == CMD_UNLK2 && at2) ? 3'd2 : 3'd0;
        3'd2: begin
          if (wdata == CMD_PROG && at1) begin
            step_d     = 3'd3;
            ers_mode_d = 1'b0;
          end else if (wdata == CMD_ERASE && at1) begin
            step_d     = 3'd3;
            ers_mode_d = 1'b1;
          end else begin
            step_d = 3'd0;
          end
        end
        3'd3: begin
          if (!ers_mode_q) begin
            prog_go = 1'b1;
            step_d  = 3'd0;
          end else begin
            step_d = (wdata == CMD_UNLK1 && at1) ? 3'd4 : 3'd0;
          end
        end
        3'd4: step_d = (wdata == CMD_UNLK2 && at2) ? 3'd5 : 3'd0;
        3'd5: begin
          erase_go = (wdata == CMD_SECT);
          step_d   = 3'd0;
        end
        default: step_d = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q     <= 3'd0;
      ers_mode_q <= 1'b0;
    end else begin
      step_q     <= step_d;
      ers_mode_q <= ers_mode_d;
    end
  end
endmodule

// File: rtl/fsr_array.sv
module fsr_array #(
  parameter int SEC_W = 2,
  parameter int OFS_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEC_W+OFS_W-1:0] rd_addr,
  output logic [7:0]             rd_data,
  input  logic                   pgm_en,
  input  logic [SEC_W+OFS_W-1:0] pgm_addr,
  input  logic [7:0]             pgm_data,
  output logic [7:0]             pgm_old,
  input  logic                   ers_en,
  input  logic [(1<<SEC_W)-1:0]  ers_mask
);
  localparam int DEPTH = 1 << OFS_W;
  localparam int NBYTE = (1 << SEC_W) * DEPTH;

  logic [7:0] mem [NBYTE];

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    localparam int SEC = g / DEPTH;
    logic hit_pgm, hit_ers;
    assign hit_pgm = pgm_en && (pgm_addr == (SEC_W+OFS_W)'(g));
    assign hit_ers = ers_en && ers_mask[SEC];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= 8'hFF;
      end else if (hit_pgm) begin
        mem[g] <= mem[g] & pgm_data;
      end else if (hit_ers) begin
        mem[g] <= 8'hFF;
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign pgm_old = mem[pgm_addr];
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import fsr_pkg::*;
#(
  parameter int SEC_W            = 2,
  parameter int OFS_W            = 4,
  parameter int PROG_CYC         = 200,
  parameter int ERASE_CYC        = 2000,
  parameter int ERASE_WINDOW_CYC = 1000,
  parameter int PROT_ERASE_CYC   = 1000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel,
  input  logic                        we,
  input  logic                        re,
  input  logic [SEC_W+OFS_W-1:0]      addr,
  input  logic [7:0]                  wdata,
  input  logic [(1<<SEC_W)-1:0]       prot,
  output logic [7:0]                  rdata
);
  localparam int ADDR_W = SEC_W + OFS_W;
  localparam int NSEC   = 1 << SEC_W;
  localparam int MAX_AB = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_CD = (ERASE_WINDOW_CYC > PROT_ERASE_CYC) ? ERASE_WINDOW_CYC : PROT_ERASE_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAXC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  fsr_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [7:0]        pd_q, pd_d;
  logic [NSEC-1:0]   mask_q, mask_d, mask_n;
  logic              err_q, err_d;
  logic              tog_q, tog_d;
  logic [7:0]        rdata_q, rdata_d;

  logic wr, rd_en, busy, in_win;
  logic prog_go, erase_go, sect_hit, reset_hit, prog_blk;
  logic pgm_en, ers_en;
  logic [7:0] arr_rd, pgm_old, status;
  logic [SEC_W-1:0] bus_sec;

  assign wr      = we && sel;
  assign rd_en   = re && sel;
  assign busy    = (st_q != ST_IDLE);
  assign in_win  = (st_q == ST_WIN);
  assign bus_sec = addr[ADDR_W-1:OFS_W];
  assign prog_blk = prog_go && !busy && prot[bus_sec];

  fsr_cmd_decode #(.OFS_W(OFS_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr       (wr),
    .cmd_en   (!busy),
    .ofs      (addr[OFS_W-1:0]),
    .wdata    (wdata),
    .prog_go  (prog_go),
    .erase_go (erase_go),
    .sect_hit (sect_hit),
    .reset_hit(reset_hit)
  );

  fsr_array #(.SEC_W(SEC_W), .OFS_W(OFS_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .rd_addr (addr),
    .rd_data (arr_rd),
    .pgm_en  (pgm_en),
    .pgm_addr(pa_q),
    .pgm_data(pd_q),
    .pgm_old (pgm_old),
    .ers_en  (ers_en),
    .ers_mask(mask_q & ~prot)
  );

  assign status = {1'b0, tog_q, err_q, 1'b0,
                   (st_q == ST_ERASE) || (st_q == ST_PWAIT), 3'b000};

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    pa_d    = pa_q;
    pd_d    = pd_q;
    mask_d  = mask_q;
    mask_n  = mask_q;
    err_d   = err_q;
    tog_d   = tog_q;
    rdata_d = rdata_q;
    pgm_en  = 1'b0;
    ers_en  = 1'b0;

    case (st_q)
      ST_IDLE: begin
        if (prog_go && !prot[bus_sec]) begin
          st_d  = ST_PROG;
          cnt_d = CNT_W'(PROG_CYC - 1);
          pa_d  = addr;
          pd_d  = wdata;
        end else if (erase_go) begin
          st_d   = ST_WIN;
          cnt_d  = CNT_W'(ERASE_WINDOW_CYC - 1);
          mask_d = NSEC'(1) << bus_sec;
        end
      end
      ST_PROG: begin
        if (cnt_q == '0) begin
          pgm_en = 1'b1;
          if ((pd_q & ~pgm_old) != 8'h00) begin
            st_d  = ST_FAULT;
            err_d = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WIN: begin
        if (sect_hit || cnt_q == '0) begin
          if (sect_hit) mask_n = mask_q | (NSEC'(1) << bus_sec);
          mask_d = mask_n;
          if ((mask_n & ~prot) == '0) begin
            st_d  = ST_PWAIT;
            cnt_d = CNT_W'(PROT_ERASE_CYC - 1);
          end else begin
            st_d  = ST_ERASE;
            cnt_d = CNT_W'(ERASE_CYC - 1);
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ERASE: begin
        if (cnt_q == '0) begin
          ers_en = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PWAIT: begin
        if (cnt_q == '0) st_d = ST_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_FAULT: st_d = ST_FAULT;
      default:  st_d = ST_IDLE;
    endcase

    if (reset_hit) begin
      st_d  = ST_IDLE;
      err_d = 1'b0;
    end

    if (rd_en) begin
      if (busy) begin
        rdata_d = status;
        tog_d   = ~tog_q;
      end else begin
        rdata_d = arr_rd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      pa_q    <= '0;
      pd_q    <= 8'h00;
      mask_q  <= '0;
      err_q   <= 1'b0;
      tog_q   <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      pa_q    <= pa_d;
      pd_q    <= pd_d;
      mask_q  <= mask_d;
      err_q   <= err_d;
      tog_q   <= tog_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       busy,
  input logic       in_win,
  input logic       tog_q,
  input logic       err_q,
  input logic       reset_hit,
  input logic       prog_blk,
  input logic [7:0] rdata
);
  p_toggle_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (tog_q != $past(tog_q)));

  p_toggle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && busy) |=> $stable(tog_q));

  p_prot_prog_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_blk |=> !busy);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !reset_hit) |=> err_q);

  p_win_bit3_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_win) |=> !rdata[3]);

  p_quiet_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rdata[7] == 1'b0 && rdata[4] == 1'b0 && rdata[2:0] == 3'b000));
endmodule

bind flash_status_resp fsr_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .busy     (busy),
  .in_win   (in_win),
  .tog_q    (tog_q),
  .err_q    (err_q),
  .reset_hit(reset_hit),
  .prog_blk (prog_blk),
  .rdata    (rdata)
);

// File: tb/test_flash_status_resp.sv
module test_flash_status_resp;
  localparam int SEC_W = 2;
  localparam int OFS_W = 4;
  localparam int AW    = SEC_W + OFS_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = 8'h00;
  logic [3:0]    prot = 4'b0000;
  logic [7:0]    rdata;

  int   n_chk = 0, n_bad = 0;
  logic tgl = 1'b0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #5 clk = ~clk;

  flash_status_resp #(
    .SEC_W(SEC_W), .OFS_W(OFS_W), .PROG_CYC(20), .ERASE_CYC(40),
    .ERASE_WINDOW_CYC(30), .PROT_ERASE_CYC(25)
  ) i_flash_status_resp (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .re(re),
    .addr(addr), .wdata(wdata), .prot(prot), .rdata(rdata)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: pops one expectation per read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (re && sel) begin
        @(negedge clk);
        if (exp_q.size() == 0) check(rdata, 8'hXX, "scoreboard empty");
        else check(rdata, exp_q.pop_front(), req_q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    exp_q.push_back(exp);
    req_q.push_back(req);
    sel = 1'b1; re = 1'b1; addr = a;
    @(negedge clk);
    sel = 1'b0; re = 1'b0;
  endtask

  // status read: bits 7,4,2,1,0 zero (R10), toggle value tracked from reset (R2)
  task automatic rds(input logic b3, input logic err, input string req);
    rd(6'h00, {1'b0, tgl, err, 1'b0, b3, 3'b000}, req);
    tgl = ~tgl;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    wr(6'h05, 8'hAA); wr(6'h0A, 8'h55); wr(6'h05, 8'hA0); wr(a, d);
  endtask

  task automatic erase(input logic [AW-1:0] a);
    wr(6'h05, 8'hAA); wr(6'h0A, 8'h55); wr(6'h05, 8'h80);
    wr(6'h05, 8'hAA); wr(6'h0A, 8'h55); wr(a, 8'h30);
  endtask

  initial begin
    #(10 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check(rdata, 8'h00, "R1 rdata after reset");
    rd(6'h00, 8'hFF, "R1 erased array");
    rd(6'h3F, 8'hFF, "R1 erased array top");

    // program and toggle
    prog(6'h03, 8'h5A);
    rds(1'b0, 1'b0, "R2 first status read");
    rds(1'b0, 1'b0, "R2 second status read toggles");
    rds(1'b0, 1'b0, "R10 third status read");
    idle(25);
    rd(6'h03, 8'h5A, "R3 programmed byte");
    rd(6'h03, 8'h5A, "R3 toggling stopped");

    prog(6'h03, 8'h52);
    idle(25);
    rd(6'h03, 8'h52, "R3 AND of old and new");

    // 0 -> 1 attempt
    prog(6'h03, 8'hFF);
    rds(1'b0, 1'b0, "R5 no error while running");
    idle(25);
    rds(1'b0, 1'b1, "R5 error bit set");
    rds(1'b0, 1'b1, "R5 error holds and toggles");
    wr(6'h00, 8'hF0);
    rd(6'h03, 8'h52, "R5 reset clears, byte not raised");

    // sector 1 content for protection tests
    prog(6'h10, 8'h33);
    idle(25);
    rd(6'h10, 8'h33, "R3 sector1 byte");

    // single-sector erase
    erase(6'h00);
    rds(1'b0, 1'b0, "R6 window bit3 low");
    idle(35);
    rds(1'b1, 1'b0, "R6 erase bit3 high");
    idle(45);
    rd(6'h03, 8'hFF, "R6 sector erased");

    // append
    prog(6'h20, 8'h11);
    idle(25);
    prog(6'h30, 8'h22);
    idle(25);
    rd(6'h20, 8'h11, "R7 setup sector2");
    erase(6'h20);
    wr(6'h30, 8'h30);
    rds(1'b1, 1'b0, "R7 append closes window");
    idle(45);
    rd(6'h20, 8'hFF, "R7 first sector erased");
    rd(6'h30, 8'hFF, "R7 appended sector erased");

    // all-protected erase
    prot = 4'b0010;
    erase(6'h10);
    rds(1'b0, 1'b0, "R8 window on protected erase");
    idle(35);
    rds(1'b1, 1'b0, "R8 protected wait status");
    idle(30);
    rd(6'h10, 8'h33, "R8 nothing erased");

    // protected program
    prog(6'h10, 8'h00);
    rd(6'h10, 8'h33, "R4 protected program ignored");

    // commands while busy
    prog(6'h06, 8'h00);
    prog(6'h07, 8'h00);
    idle(25);
    rd(6'h07, 8'hFF, "R9 command while busy ignored");
    rd(6'h06, 8'h00, "R9 first program done");

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule